// File: doc/BRIEF.md
# Real-Time Clock Seconds Update and Alarm Engine

This block advances a packed-BCD calendar by one second for every one-cycle tick it receives. It covers seconds, minutes and hours in 24-hour form, day of the week, day of the month, month, two-digit year and a separate century byte. Month lengths follow the calendar, including a 29-day February when the year is a multiple of four.

Each update that reaches the visible time can raise an update-ended event. It can also raise an alarm event when seconds, minutes and hours equal three alarm bytes. An alarm byte whose two top bits are both set matches any value. The events come out as one-cycle pulses, together with a byte mask that the enclosing block ORs into its interrupt flag register.

A set-mode input freezes the visible time and suppresses both events while an internal copy keeps counting. A load port presets both copies. The enclosing block decides how software reaches these controls.

Top module: `rtc_second_update`

## Requirements
- R1: After reset the visible time reads 00:00:00, day of week 01, date 01, month 01, year 00, century RESET_CENTURY (default 20), and upd_pulse, alm_pulse, flag_set and irq_pulse are all zero.
- R2: Each tick adds one to seconds in BCD, one cycle after the tick. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the date.
- R3: The date wraps to 01 and carries into the month after 30 in months 04, 06, 09 and 11, and after 31 in the other months. February ends at 28, or at 29 when the binary value of the BCD year is divisible by 4. The month wraps from 12 to 01 and increments the year.
- R4: Day of week increments whenever the date advances and wraps from 07 to 01.
- R5: The year wraps from 99 to 00 and increments the century.
- R6: While set_mode is 1, the visible time holds and neither pulse fires, but the internal time still advances on every tick. The first tick after set_mode returns to 0 shows the internal time plus that tick.
- R7: A tick with set_mode 0 and upd_ie 1 gives upd_pulse for exactly the next cycle. No tick, or upd_ie 0, gives no upd_pulse.
- R8: With alm_ie 1 and set_mode 0, a tick gives alm_pulse in the next cycle exactly when the updated seconds, minutes and hours each equal their alarm byte (alm_sec, alm_min, alm_hour). Any mismatch, or alm_ie 0, gives no alm_pulse.
- R9: An alarm byte whose bits 7:6 are 11 matches every value of its field. A byte whose bits 7:6 are 10 is compared normally.
- R10: load_en writes load_val into both the visible and the internal time in the next cycle, overrides a simultaneous tick and raises no pulse. Byte order from bit 0 upward: seconds, minutes, hours, date, month, year, century, day of week.
- R11: flag_set is 0x90 for an update event, 0xA0 for an alarm event, 0xB0 for both and 0x00 otherwise. irq_pulse is 1 exactly when flag_set is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| set_mode | input | 1 | Freeze visible time and events |
| upd_ie | input | 1 | Update-ended event enable |
| alm_ie | input | 1 | Alarm event enable |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| load_en | input | 1 | Preset both time copies |
| load_val | input | 64 | Preset value, byte order as in R10 |
| time_sec | output | 8 | Visible seconds (BCD) |
| time_min | output | 8 | Visible minutes (BCD) |
| time_hour | output | 8 | Visible hours (BCD) |
| time_wday | output | 8 | Visible day of week 1..7 (BCD) |
| time_mday | output | 8 | Visible date (BCD) |
| time_month | output | 8 | Visible month (BCD) |
| time_year | output | 8 | Visible year 00..99 (BCD) |
| time_cent | output | 8 | Visible century (BCD) |
| upd_pulse | output | 1 | Update-ended event, one cycle |
| alm_pulse | output | 1 | Alarm event, one cycle |
| flag_set | output | 8 | Bits to OR into the flag register |
| irq_pulse | output | 1 | Interrupt request, one cycle |

## Verification
The calendar is tested by presetting times just before each boundary:
- a minute carry, which shows a carry that stays within the time fields;
- the end of a 30-day month, a 31-day month, February in a common year and February in a leap year, which separate the four month-length rules;
- the end of a year ending in 99, which checks the century carry and the day-of-week wrap together.

Alarm patterns are an exact match, a one-second miss, an hours miss under two wildcards, and a 10 top-bit code that must not act as a wildcard. Set mode is run with both enables on, which shows that the visible hold and the event suppression are separate from the internal count. A preset that coincides with a tick shows which of the two wins.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
   localparam int BYTE_W     = 8;
   localparam int NUM_FIELDS = 8;
   localparam int CHAIN_LEN  = 7;
   // field index: carry chain order, day of week last
   localparam int F_SEC   = 0;
   localparam int F_MIN   = 1;
   localparam int F_HOUR  = 2;
   localparam int F_MDAY  = 3;
   localparam int F_MONTH = 4;
   localparam int F_YEAR  = 5;
   localparam int F_CENT  = 6;
   localparam int F_WDAY  = 7;
   // flag register bit positions decoded by the enclosing block
   localparam int FLAG_IRQ = 7;
   localparam int FLAG_ALM = 5;
   localparam int FLAG_UPD = 4;

   typedef logic [BYTE_W-1:0] bcd_t;
   typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] cal_t;

   function automatic bcd_t bcd_inc(input bcd_t b);
      logic [3:0] tens;
      tens = b[7:4] + 4'd1;
      if (b[3:0] >= 4'd9) return {tens, 4'h0};
      return {b[7:4], b[3:0] + 4'd1};
   endfunction

   function automatic logic bcd_leap(input bcd_t y);
      logic [6:0] bin;
      bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
      return bin[1:0] == 2'b00;
   endfunction

   function automatic bcd_t month_end(input bcd_t m, input bcd_t y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd_t field_low(input int idx);
      return (idx == F_MDAY || idx == F_MONTH || idx == F_WDAY) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd_t field_high(input int idx);
      case (idx)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_MONTH:      return 8'h12;
         F_WDAY:       return 8'h07;
         default:      return 8'h99;
      endcase
   endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
   import rtc_sec_pkg::*;
(
   input  bcd_t cur,
   input  bcd_t lo,
   input  bcd_t hi,
   input  logic inc,
   output bcd_t nxt,
   output logic wrap
);
   always_comb begin
      wrap = inc && (cur >= hi);
      if (wrap)     nxt = lo;
      else if (inc) nxt = bcd_inc(cur);
      else          nxt = cur;
   end
endmodule

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
   import rtc_sec_pkg::*;
(
   input  cal_t cur_time,
   input  logic step,
   output cal_t nxt_time
);
   logic [CHAIN_LEN:0] carry;
   logic cent_wrap_unused;
   logic wday_wrap_unused;
   bcd_t mday_last;

   assign carry[0]         = step;
   assign cent_wrap_unused = carry[CHAIN_LEN];
   assign mday_last        = month_end(cur_time[F_MONTH], cur_time[F_YEAR]);

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_chain
      bcd_t lo_b, hi_b;
      always_comb begin
         lo_b = field_low(i);
         hi_b = (i == F_MDAY) ? mday_last : field_high(i);
      end
      rtc_bcd_step u_step (
         .cur (cur_time[i]),
         .lo  (lo_b),
         .hi  (hi_b),
         .inc (carry[i]),
         .nxt (nxt_time[i]),
         .wrap(carry[i+1])
      );
   end

   rtc_bcd_step u_wday (
      .cur (cur_time[F_WDAY]),
      .lo  (field_low(F_WDAY)),
      .hi  (field_high(F_WDAY)),
      .inc (carry[F_MDAY]),
      .nxt (nxt_time[F_WDAY]),
      .wrap(wday_wrap_unused)
   );
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
   import rtc_sec_pkg::*;
#(
   parameter int N_FIELDS = 3
) (
   input  logic [N_FIELDS-1:0][BYTE_W-1:0] now,
   input  logic [N_FIELDS-1:0][BYTE_W-1:0] target,
   output logic                            hit
);
   logic [N_FIELDS-1:0] fld_ok;

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
      logic wild;
      assign wild      = (target[i][7:6] == 2'b11);
      assign fld_ok[i] = wild || (now[i] == target[i]);
   end

   assign hit = &fld_ok;
endmodule

// File: rtl/rtc_second_update.sv
module rtc_second_update
   import rtc_sec_pkg::*;
#(
   parameter logic [7:0] RESET_CENTURY = 8'h20,
   parameter int         ALARM_FIELDS  = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_1hz,
   input  logic        set_mode,
   input  logic        upd_ie,
   input  logic        alm_ie,
   input  logic [7:0]  alm_sec,
   input  logic [7:0]  alm_min,
   input  logic [7:0]  alm_hour,
   input  logic        load_en,
   input  logic [63:0] load_val,
   output logic [7:0]  time_sec,
   output logic [7:0]  time_min,
   output logic [7:0]  time_hour,
   output logic [7:0]  time_wday,
   output logic [7:0]  time_mday,
   output logic [7:0]  time_month,
   output logic [7:0]  time_year,
   output logic [7:0]  time_cent,
   output logic        upd_pulse,
   output logic        alm_pulse,
   output logic [7:0]  flag_set,
   output logic        irq_pulse
);
   localparam logic CENT_OK  = (RESET_CENTURY[3:0] <= 4'd9) && (RESET_CENTURY[7:4] <= 4'd9);
   localparam logic ALARM_OK = (ALARM_FIELDS >= 1) && (ALARM_FIELDS <= 3);

   initial begin
      assert (CENT_OK)  else $error("RESET_CENTURY must be packed BCD");
      assert (ALARM_OK) else $error("ALARM_FIELDS must be 1..3");
   end

   cal_t kept_q, shown_q, kept_nxt, reset_val;
   logic alarm_hit, upd_q, alm_q, live;
   logic [2:0][BYTE_W-1:0] alarm_all;

   always_comb begin
      reset_val          = '0;
      reset_val[F_MDAY]  = 8'h01;
      reset_val[F_MONTH] = 8'h01;
      reset_val[F_WDAY]  = 8'h01;
      reset_val[F_CENT]  = RESET_CENTURY;
   end

   rtc_calendar_next u_next (
      .cur_time(kept_q),
      .step    (tick_1hz),
      .nxt_time(kept_nxt)
   );

   assign alarm_all = {alm_hour, alm_min, alm_sec};

   rtc_alarm_cmp #(.N_FIELDS(ALARM_FIELDS)) u_alarm (
      .now   (kept_nxt[ALARM_FIELDS-1:0]),
      .target(alarm_all[ALARM_FIELDS-1:0]),
      .hit   (alarm_hit)
   );

   assign live = tick_1hz && !set_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kept_q  <= reset_val;
         shown_q <= reset_val;
         upd_q   <= 1'b0;
         alm_q   <= 1'b0;
      end else if (load_en) begin
         kept_q  <= load_val;
         shown_q <= load_val;
         upd_q   <= 1'b0;
         alm_q   <= 1'b0;
      end else begin
         kept_q <= kept_nxt;
         if (live) shown_q <= kept_nxt;
         upd_q <= live && upd_ie;
         alm_q <= live && alm_ie && alarm_hit;
      end
   end

   assign time_sec   = shown_q[F_SEC];
   assign time_min   = shown_q[F_MIN];
   assign time_hour  = shown_q[F_HOUR];
   assign time_wday  = shown_q[F_WDAY];
   assign time_mday  = shown_q[F_MDAY];
   assign time_month = shown_q[F_MONTH];
   assign time_year  = shown_q[F_YEAR];
   assign time_cent  = shown_q[F_CENT];
   assign upd_pulse  = upd_q;
   assign alm_pulse  = alm_q;

   always_comb begin
      flag_set           = '0;
      flag_set[FLAG_IRQ] = upd_q || alm_q;
      flag_set[FLAG_ALM] = alm_q;
      flag_set[FLAG_UPD] = upd_q;
   end
   assign irq_pulse = upd_q || alm_q;

   assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !load_en && kept_q[F_SEC] == 8'h59) |=> (kept_q[F_SEC] == 8'h00));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mode && !load_en) |=> ($stable(time_sec) && $stable(time_min) && $stable(time_hour)));

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_mode |=> (!upd_pulse && !alm_pulse));

   assert_upd_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && upd_ie && !set_mode && !load_en) |=> upd_pulse);

   assert_upd_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |-> $past(tick_1hz));

   assert_alm_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alm_pulse |-> ($past(alm_ie) && $past(tick_1hz)));

   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (time_sec == $past(load_val[7:0]) && !irq_pulse));
endmodule

// File: tb/test_rtc_second_update.sv
module test_rtc_second_update;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0, set_mode = 1'b0, upd_ie = 1'b0, alm_ie = 1'b0;
   logic [7:0]  alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
   logic        load_en = 1'b0;
   logic [63:0] load_val = '0;
   logic [7:0]  time_sec, time_min, time_hour, time_wday, time_mday;
   logic [7:0]  time_month, time_year, time_cent, flag_set;
   logic        upd_pulse, alm_pulse, irq_pulse;
   int total = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rtc_second_update i_rtc_second_update (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .set_mode(set_mode),
      .upd_ie(upd_ie), .alm_ie(alm_ie), .alm_sec(alm_sec), .alm_min(alm_min),
      .alm_hour(alm_hour), .load_en(load_en), .load_val(load_val),
      .time_sec(time_sec), .time_min(time_min), .time_hour(time_hour),
      .time_wday(time_wday), .time_mday(time_mday), .time_month(time_month),
      .time_year(time_year), .time_cent(time_cent), .upd_pulse(upd_pulse),
      .alm_pulse(alm_pulse), .flag_set(flag_set), .irq_pulse(irq_pulse)
   );

   // order: sec,min,hour,mday,month,year,cent,wday from bit 0
   function automatic logic [63:0] pack(input logic [7:0] s, mi, h, d, mo, y, c, w);
      return {w, c, y, mo, d, h, mi, s};
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic chk_time(input string req, input logic [63:0] exp);
      chk(req, pack(time_sec, time_min, time_hour, time_mday, time_month,
                    time_year, time_cent, time_wday), exp);
   endtask

   task automatic load(input logic [63:0] v);
      @(negedge clk); load_en = 1'b1; load_val = v;
      @(negedge clk); load_en = 1'b0;
   endtask

   task automatic tick_once();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic t_reset();
      chk_time("R1 reset time", pack(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h20, 8'h01));
      chk("R1 reset events", {upd_pulse, alm_pulse, irq_pulse, flag_set}, '0);
   endtask

   task automatic t_count();
      for (int k = 0; k < 3; k++) tick_once();
      chk("R2 three ticks", time_sec, 8'h03);
      load(pack(8'h59, 8'h14, 8'h00, 8'h05, 8'h06, 8'h21, 8'h20, 8'h02));
      tick_once();
      chk_time("R2 minute carry", pack(8'h00, 8'h15, 8'h00, 8'h05, 8'h06, 8'h21, 8'h20, 8'h02));
   endtask

   task automatic t_calendar();
      load(pack(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h20, 8'h07));
      chk_time("R10 load", pack(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h20, 8'h07));
      tick_once();
      chk("R2 sec 59", time_sec, 8'h59);
      tick_once();
      chk_time("R5 R4 year and century", pack(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h21, 8'h01));
      load(pack(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h20, 8'h03));
      tick_once();
      chk_time("R3 common Feb", pack(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h20, 8'h04));
      load(pack(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h20, 8'h02));
      tick_once();
      chk_time("R3 leap Feb 29", pack(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h20, 8'h03));
      load(pack(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h20, 8'h03));
      tick_once();
      chk_time("R3 leap Feb end", pack(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h24, 8'h20, 8'h04));
      load(pack(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h25, 8'h20, 8'h07));
      tick_once();
      chk_time("R3 R4 30-day month", pack(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h25, 8'h20, 8'h01));
      load(pack(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h25, 8'h20, 8'h04));
      tick_once();
      chk_time("R3 31-day month", pack(8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h25, 8'h20, 8'h05));
   endtask

   task automatic t_load_wins();
      upd_ie = 1'b1;
      @(negedge clk); load_en = 1'b1; tick_1hz = 1'b1;
      load_val = pack(8'h07, 8'h08, 8'h09, 8'h10, 8'h11, 8'h12, 8'h20, 8'h03);
      @(negedge clk); load_en = 1'b0; tick_1hz = 1'b0;
      chk_time("R10 load beats tick", pack(8'h07, 8'h08, 8'h09, 8'h10, 8'h11, 8'h12, 8'h20, 8'h03));
      chk("R10 no pulse on load", {upd_pulse, irq_pulse}, 2'b00);
      upd_ie = 1'b0;
   endtask

   task automatic t_set_mode();
      int seen = 0;
      load(pack(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h20, 8'h01));
      upd_ie = 1'b1; alm_ie = 1'b1;
      alm_sec = 8'hC0; alm_min = 8'hC0; alm_hour = 8'hC0;
      set_mode = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick_once();
         if (irq_pulse) seen++;
      end
      chk("R6 frozen sec", time_sec, 8'h10);
      chk("R6 no events in set mode", seen, 0);
      set_mode = 1'b0;
      tick_once();
      chk("R6 internal kept counting", time_sec, 8'h14);
      chk("R11 both events", flag_set, 8'hB0);
      upd_ie = 1'b0; alm_ie = 1'b0;
   endtask

   task automatic t_update();
      upd_ie = 1'b1;
      tick_once();
      chk("R7 R11 update flag", {upd_pulse, irq_pulse, flag_set}, {2'b11, 8'h90});
      @(negedge clk);
      chk("R7 one cycle only", upd_pulse, 1'b0);
      upd_ie = 1'b0;
      tick_once();
      chk("R7 R11 disabled", {upd_pulse, irq_pulse, flag_set}, '0);
   endtask

   task automatic t_alarm();
      alm_sec = 8'h45; alm_min = 8'h30; alm_hour = 8'h12; alm_ie = 1'b1;
      load(pack(8'h44, 8'h30, 8'h12, 8'h01, 8'h01, 8'h00, 8'h20, 8'h01));
      tick_once();
      chk("R8 R11 exact match", {alm_pulse, irq_pulse, flag_set}, {2'b11, 8'hA0});
      tick_once();
      chk("R8 next second no match", {alm_pulse, flag_set}, '0);
      alm_ie = 1'b0;
      load(pack(8'h44, 8'h30, 8'h12, 8'h01, 8'h01, 8'h00, 8'h20, 8'h01));
      tick_once();
      chk("R8 disabled", alm_pulse, 1'b0);
   endtask

   task automatic t_wildcard();
      alm_sec = 8'hC0; alm_min = 8'hFF; alm_hour = 8'h12; alm_ie = 1'b1;
      load(pack(8'h33, 8'h07, 8'h12, 8'h01, 8'h01, 8'h00, 8'h20, 8'h01));
      tick_once();
      chk("R9 wildcards match", {alm_pulse, flag_set}, {1'b1, 8'hA0});
      load(pack(8'h33, 8'h07, 8'h13, 8'h01, 8'h01, 8'h00, 8'h20, 8'h01));
      tick_once();
      chk("R9 hour mismatch", alm_pulse, 1'b0);
      alm_sec = 8'h80;
      load(pack(8'h33, 8'h07, 8'h12, 8'h01, 8'h01, 8'h00, 8'h20, 8'h01));
      tick_once();
      chk("R9 code 10 not wild", alm_pulse, 1'b0);
      alm_ie = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_calendar();
      t_load_wins();
      t_set_mode();
      t_update();
      t_alarm();
      t_wildcard();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule